// File: doc/BRIEF.md
# Multicast Grant Hysteresis Generator

This block turns a single shared multicast occupancy count into one grant flag per priority level. Each priority owns a high mark and a low mark. A priority loses its grant as soon as occupancy rises above its high mark. It gets the grant back only once occupancy has fallen below its low mark. The gap between the two marks keeps the flag from toggling on every small change in occupancy.

The comparison runs on every clock, in one small state machine per priority. The grant vector that attached devices see is a separate registered table. That table copies the live state only on a packet-cycle strobe, so every consumer sees one consistent snapshot for the whole packet cycle. A one-cycle change flag marks each strobe at which the snapshot differs from the one before it.

Each per-priority machine has two states:
- GRANTED: the grant is on.
- WITHHELD: the grant is off.

It has two transitions:
- WITHDRAW: GRANTED to WITHHELD, taken when occupancy is above the high mark.
- RESTORE: WITHHELD to GRANTED, taken when occupancy is below the low mark. If the low mark is set above the high mark, RESTORE is taken instead whenever occupancy is at or below the high mark.

Top module: `mcast_grant_hyst`

## Requirements
- R1: During and after reset, all live grants and every bit of `grant_tbl` are 1, and `grant_chg` is 0.
- R2: A priority whose high mark is exceeded (occupancy strictly greater than the mark) is WITHHELD from the next clock. Occupancy equal to the high mark does not withdraw the grant.
- R3: A WITHHELD priority returns to GRANTED on the clock after occupancy is strictly below its low mark. Occupancy equal to the low mark does not restore it.
- R4: While occupancy lies between the low and high marks, both inclusive, a priority keeps its previous state.
- R5: The state is evaluated on every clock, so a one-clock excursion above a high mark between strobes is visible as a withdrawn grant at the next strobe.
- R6: `grant_tbl` changes only on the clock edge at which `pkt_strobe` is 1. On that edge it takes the live state.
- R7: `grant_chg` is 1 for exactly the cycle after a strobe edge whose new `grant_tbl` differs from the previous one. Otherwise it is 0, including after strobes that leave the table unchanged.
- R8: When a priority's low mark is greater than its high mark, its grant is simply (occupancy <= high mark), with no hysteresis.
- R9: Priorities are independent. Bit i of `grant_tbl` is priority i, and priority i's marks occupy bits [i*CNT_W +: CNT_W] of `thr_hi` and `thr_lo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| occ_count | input | CNT_W | Shared multicast occupancy count |
| thr_hi | input | NPRIO*CNT_W | High marks, one CNT_W slice per priority |
| thr_lo | input | NPRIO*CNT_W | Low marks, one CNT_W slice per priority |
| pkt_strobe | input | 1 | Packet-cycle boundary; latches the grant table |
| grant_tbl | output | NPRIO | Latched grant vector, one bit per priority |
| grant_chg | output | 1 | One-cycle flag: the latched vector changed |

## Verification
The bench builds the block with NPRIO = 4 and CNT_W = 10, so the marks can be spread far enough apart that every priority can be driven into a different state by one occupancy value.

Priority 3 is given a low mark above its high mark. This keeps the configuration-error rule running alongside the three normal hysteresis windows. It also allows values that sit exactly on a mark, in the middle of a window and just past a mark to be applied one after another.

Held occupancy values with no strobe show that the table freezes between strobes. A single-clock excursion shows that the live evaluation runs on every clock.

// File: rtl/mcg_pkg.sv
package mcg_pkg;
    typedef enum logic {
        ST_GRANTED  = 1'b0,
        ST_WITHHELD = 1'b1
    } prio_state_e;
endpackage

// File: rtl/mcg_prio_fsm.sv
module mcg_prio_fsm
    import mcg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] occ,
    input  logic [CNT_W-1:0] hi_mark,
    input  logic [CNT_W-1:0] lo_mark,
    output logic             grant_o
);
    prio_state_e state_q, state_d;
    logic        cfg_err, above_hi, below_lo, restore_ok;

    assign cfg_err    = lo_mark > hi_mark;
    assign above_hi   = occ > hi_mark;
    assign below_lo   = occ < lo_mark;
    assign restore_ok = cfg_err ? !above_hi : below_lo;

    // next-state: WITHDRAW and RESTORE transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GRANTED:  if (above_hi)   state_d = ST_WITHHELD;
            ST_WITHHELD: if (restore_ok) state_d = ST_GRANTED;
            default:                     state_d = ST_GRANTED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_GRANTED;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        grant_o = (state_q == ST_GRANTED);
    end

    a_r2_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
        (occ > hi_mark) |=> !grant_o);
    a_r3_restore: assert property (@(posedge clk) disable iff (!rst_n)
        ((occ < lo_mark) && (occ <= hi_mark)) |=> grant_o);
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((lo_mark <= hi_mark) && (occ >= lo_mark) && (occ <= hi_mark)) |=> $stable(grant_o));
    a_r8_cfg_err: assert property (@(posedge clk) disable iff (!rst_n)
        ((lo_mark > hi_mark) && (occ <= hi_mark)) |=> grant_o);
endmodule

// File: rtl/mcg_table_latch.sv
module mcg_table_latch #(
    parameter int NPRIO = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [NPRIO-1:0] grant_live,
    output logic [NPRIO-1:0] grant_tbl,
    output logic             grant_chg
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_tbl <= '1;
            grant_chg <= 1'b0;
        end else begin
            grant_chg <= 1'b0;
            if (strobe) begin
                grant_tbl <= grant_live;
                grant_chg <= (grant_live != grant_tbl);
            end
        end
    end

    a_r6_tbl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(grant_tbl));
    a_r6_tbl_take: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (grant_tbl == $past(grant_live)));
    a_r7_chg_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> !grant_chg);
endmodule

// File: rtl/mcast_grant_hyst.sv
module mcast_grant_hyst #(
    parameter int NPRIO = 4,
    parameter int CNT_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CNT_W-1:0]       occ_count,
    input  logic [NPRIO*CNT_W-1:0] thr_hi,
    input  logic [NPRIO*CNT_W-1:0] thr_lo,
    input  logic                   pkt_strobe,
    output logic [NPRIO-1:0]       grant_tbl,
    output logic                   grant_chg
);
    logic [NPRIO-1:0] grant_live;

    for (genvar p = 0; p < NPRIO; p++) begin : g_prio
        mcg_prio_fsm #(.CNT_W(CNT_W)) u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .occ     (occ_count),
            .hi_mark (thr_hi[p*CNT_W +: CNT_W]),
            .lo_mark (thr_lo[p*CNT_W +: CNT_W]),
            .grant_o (grant_live[p])
        );
    end

    mcg_table_latch #(.NPRIO(NPRIO)) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (pkt_strobe),
        .grant_live (grant_live),
        .grant_tbl  (grant_tbl),
        .grant_chg  (grant_chg)
    );

    a_r7_chg_match: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_strobe |=> (grant_chg == (grant_tbl != $past(grant_tbl))));
endmodule

// File: tb/sim_mcast_grant_hyst.sv
module sim_mcast_grant_hyst;
    localparam int NPRIO = 4;
    localparam int CNT_W = 10;

    typedef struct packed {
        logic [CNT_W-1:0] occ;
        logic [NPRIO-1:0] tbl;
        logic             chg;
    } vec_t;

    // thresholds: P0 50/100, P1 150/200, P2 250/300, P3 lo 40 > hi 20 (config error)
    localparam vec_t VECS [14] = '{
        '{10'd10,  4'b1111, 1'b0},  // R1/R8 P3 granted at 10
        '{10'd20,  4'b1111, 1'b0},  // R8 P3 equal to hi stays granted
        '{10'd21,  4'b0111, 1'b1},  // R8 P3 withdrawn
        '{10'd100, 4'b0111, 1'b0},  // R2 equal to hi keeps P0
        '{10'd101, 4'b0110, 1'b1},  // R2 P0 withdrawn
        '{10'd60,  4'b0110, 1'b0},  // R4 between marks hold
        '{10'd50,  4'b0110, 1'b0},  // R3 equal to lo no restore
        '{10'd49,  4'b0111, 1'b1},  // R3 P0 restored
        '{10'd301, 4'b0000, 1'b1},  // R2 all withdrawn
        '{10'd260, 4'b0000, 1'b0},  // R4 P2 between holds
        '{10'd249, 4'b0100, 1'b1},  // R3 P2 restored, R9
        '{10'd160, 4'b0100, 1'b0},  // R4 P1 between holds, R9
        '{10'd149, 4'b0110, 1'b1},  // R3 P1 restored
        '{10'd0,   4'b1111, 1'b1}   // R3/R8 all restored
    };

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [CNT_W-1:0]       occ_count = '0;
    logic [NPRIO*CNT_W-1:0] thr_hi = {10'd20, 10'd300, 10'd200, 10'd100};
    logic [NPRIO*CNT_W-1:0] thr_lo = {10'd40, 10'd250, 10'd150, 10'd50};
    logic                   pkt_strobe = 1'b0;
    logic [NPRIO-1:0]       grant_tbl;
    logic                   grant_chg;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    mcast_grant_hyst #(.NPRIO(NPRIO), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .occ_count(occ_count), .thr_hi(thr_hi),
        .thr_lo(thr_lo), .pkt_strobe(pkt_strobe), .grant_tbl(grant_tbl),
        .grant_chg(grant_chg)
    );

    task automatic check(string req, logic [NPRIO-1:0] tbl_exp, logic chg_exp);
        n_run++;
        if (grant_tbl !== tbl_exp || grant_chg !== chg_exp) begin
            n_fail++;
            $display("FAIL %s: tbl=%b chg=%b expected tbl=%b chg=%b",
                     req, grant_tbl, grant_chg, tbl_exp, chg_exp);
        end
    endtask

    task automatic strobe_once();
        @(negedge clk) pkt_strobe = 1'b1;
        @(negedge clk) pkt_strobe = 1'b0;
    endtask

    task automatic apply(logic [CNT_W-1:0] v);
        @(negedge clk) occ_count = v;
        @(negedge clk);
        strobe_once();
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", 4'b1111, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 after reset", 4'b1111, 1'b0);

        for (int i = 0; i < 14; i++) begin
            apply(VECS[i].occ);
            check($sformatf("vector %0d (R2/R3/R4/R8/R9)", i), VECS[i].tbl, VECS[i].chg);
        end

        // R7: flag drops the next cycle
        @(negedge clk);
        check("R7 flag one cycle", 4'b1111, 1'b0);

        // R6: table frozen without strobe
        @(negedge clk) occ_count = 10'd301;
        repeat (4) @(negedge clk);
        check("R6 frozen without strobe", 4'b1111, 1'b0);
        strobe_once();
        check("R6 takes live on strobe", 4'b0000, 1'b1);
        strobe_once();
        check("R7 repeat strobe no change", 4'b0000, 1'b0);

        // back to all granted
        apply(10'd0);
        check("R3 all restored", 4'b1111, 1'b1);

        // R5: one-clock excursion above P0 high mark
        @(negedge clk) occ_count = 10'd110;
        @(negedge clk) occ_count = 10'd70;
        repeat (3) @(negedge clk);
        check("R5 still frozen", 4'b1111, 1'b0);
        strobe_once();
        check("R5 excursion captured", 4'b0110, 1'b1);

        // R1: reset mid-run
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", 4'b1111, 1'b0);
        rst_n = 1'b1;
        occ_count = 10'd0;
        strobe_once();
        check("R1 stays granted", 4'b1111, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule